// File: doc/BRIEF.md
# Aging-Counter Page Replacement Helper

This block keeps an approximate record of how recently each of a fixed set of page frames has been used. Every frame owns a one-bit "touched" flag, set whenever an access to that frame is reported, and an 8-bit age history. On each aging tick, every frame's touched flag is pushed into the top bit of its history, the older bits move one place toward the least significant end, and the flag is cleared for the next interval. The interval is set entirely by whoever drives the tick input, so ticks may arrive at any spacing.

When replacement logic needs a frame to evict, it raises a victim request. A sequential engine then visits the frames one per cycle and reports the frame whose history is numerically smallest, which approximates the least recently used frame. Software can also clear a single frame's touched flag through a clear port.

Top module: `aging_lru_unit`

## Requirements
- R1: After a synchronous reset, all touched flags and histories are zero, `vic_busy` and `vic_done` are low and `vic_frame` is 0.
- R2: A cycle with `acc_valid` high sets the touched flag of frame `acc_frame` at the next clock edge.
- R3: A cycle with `clr_valid` high clears the touched flag of frame `clr_frame`; when an access to the same frame is reported in the same cycle, the access wins and the flag ends up set.
- R4: An aging step replaces each history H with {flag, H[7:1]}: the flag enters bit 7 and every other bit moves one place down (10101010 with the flag set becomes 11010101).
- R5: Every touched flag is cleared by the aging step that shifts it into the history.
- R6: An access reported in the same cycle as an aging step sets the flag after that step, so it is recorded in the following interval.
- R7: The reported victim is the frame with the numerically smallest history; among equal smallest values, the lowest frame index is reported.
- R8: A `vic_req` seen while no scan runs makes `vic_busy` high from the next cycle for exactly NUM_FRAMES cycles, followed by one cycle with `vic_done` high; `vic_frame` is updated in that cycle and held until the next completed scan.
- R9: `vic_req` while `vic_busy` is high is ignored: the running scan keeps its length and result, and no extra scan is started.
- R10: A tick that arrives while a scan runs is not applied during the scan; a single aging step is applied at the edge that ends the `vic_done` cycle, and several ticks during one scan merge into that one step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access to a frame is being reported |
| acc_frame | input | FRAME_IDX_W | Index of the accessed frame |
| tick | input | 1 | Aging tick, one cycle per interval |
| clr_valid | input | 1 | Clear one frame's touched flag |
| clr_frame | input | FRAME_IDX_W | Index of the frame whose flag is cleared |
| vic_req | input | 1 | Start a victim search |
| vic_busy | output | 1 | Victim search in progress |
| vic_done | output | 1 | One-cycle pulse: search finished, `vic_frame` valid |
| vic_frame | output | FRAME_IDX_W | Index of the selected eviction victim |

## Verification
The assertions watch every cycle for the scan's handshake shape (start after an idle request, busy length of exactly NUM_FRAMES, a single done pulse right after busy falls), for the touched flag being set after an access and cleared by aging, for the incoming top history bit matching the flag, and for histories staying frozen while a scan runs. Which frame is chosen, the lowest-index rule on ties, the priority of an access over a clear, the late counting of an access that coincides with a tick, and the merging of ticks deferred during a scan are only visible through the victim reported after a chosen sequence of accesses and ticks, so the bench's directed scenarios and its cycle-by-cycle model carry those.

// File: rtl/aging_lru_pkg.sv
package aging_lru_pkg;

  localparam int unsigned AGE_W = 8;

  typedef logic [AGE_W-1:0] age_t;

  typedef enum logic [1:0] {
    SCAN_IDLE   = 2'd0,
    SCAN_RUN    = 2'd1,
    SCAN_REPORT = 2'd2
  } scan_state_e;

endpackage

// File: rtl/lru_ref_bits.sv
module lru_ref_bits #(
  parameter int unsigned NUM_FRAMES  = 16,
  parameter int unsigned FRAME_IDX_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   acc_valid,
  input  logic [FRAME_IDX_W-1:0] acc_frame,
  input  logic                   clr_valid,
  input  logic [FRAME_IDX_W-1:0] clr_frame,
  input  logic                   age_fire,
  output logic [NUM_FRAMES-1:0]  ref_q
);

  for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_flag
    logic hit_acc;
    logic hit_clr;

    assign hit_acc = acc_valid && (acc_frame == FRAME_IDX_W'(i));
    assign hit_clr = clr_valid && (clr_frame == FRAME_IDX_W'(i));

    // aging and clearing drop the flag first; a same-cycle access sets it again
    always_ff @(posedge clk) begin
      if (rst) begin
        ref_q[i] <= 1'b0;
      end else begin
        ref_q[i] <= hit_acc | (ref_q[i] & ~age_fire & ~hit_clr);
      end
    end
  end

endmodule

// File: rtl/lru_history.sv
module lru_history
  import aging_lru_pkg::*;
#(
  parameter int unsigned NUM_FRAMES = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  age_fire,
  input  logic [NUM_FRAMES-1:0] ref_q,
  output age_t                  hist_q [NUM_FRAMES]
);

  for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_hist
    always_ff @(posedge clk) begin
      if (rst) begin
        hist_q[i] <= '0;
      end else if (age_fire) begin
        hist_q[i] <= {ref_q[i], hist_q[i][AGE_W-1:1]};
      end
    end
  end

endmodule

// File: rtl/lru_victim_scan.sv
module lru_victim_scan
  import aging_lru_pkg::*;
#(
  parameter int unsigned NUM_FRAMES  = 16,
  parameter int unsigned FRAME_IDX_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  age_t                   hist [NUM_FRAMES],
  output logic                   busy,
  output logic                   done,
  output logic [FRAME_IDX_W-1:0] victim
);

  localparam logic [FRAME_IDX_W-1:0] LAST_IDX = FRAME_IDX_W'(NUM_FRAMES - 1);

  scan_state_e            state_q;
  logic [FRAME_IDX_W-1:0] scan_idx_q;
  logic [FRAME_IDX_W-1:0] best_idx_q;
  age_t                   best_val_q;
  age_t                   cur_val;
  logic                   cur_lower;

  assign cur_val   = hist[scan_idx_q];
  // strict compare keeps the earliest frame on ties
  assign cur_lower = cur_val < best_val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SCAN_IDLE;
      scan_idx_q <= '0;
      best_idx_q <= '0;
      best_val_q <= '1;
      victim     <= '0;
    end else begin
      unique case (state_q)
        SCAN_RUN: begin
          if (cur_lower) begin
            best_val_q <= cur_val;
            best_idx_q <= scan_idx_q;
          end
          if (scan_idx_q == LAST_IDX) begin
            state_q <= SCAN_REPORT;
            victim  <= cur_lower ? scan_idx_q : best_idx_q;
          end else begin
            scan_idx_q <= scan_idx_q + 1'b1;
          end
        end
        default: begin
          if (start) begin
            state_q    <= SCAN_RUN;
            scan_idx_q <= '0;
            best_idx_q <= '0;
            best_val_q <= '1;
          end else begin
            state_q <= SCAN_IDLE;
          end
        end
      endcase
    end
  end

  assign busy = (state_q == SCAN_RUN);
  assign done = (state_q == SCAN_REPORT);

endmodule

// File: rtl/aging_lru_unit.sv
module aging_lru_unit
  import aging_lru_pkg::*;
#(
  parameter int unsigned NUM_FRAMES  = 16,
  parameter int unsigned FRAME_IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   acc_valid,
  input  logic [FRAME_IDX_W-1:0] acc_frame,
  input  logic                   tick,
  input  logic                   clr_valid,
  input  logic [FRAME_IDX_W-1:0] clr_frame,
  input  logic                   vic_req,
  output logic                   vic_busy,
  output logic                   vic_done,
  output logic [FRAME_IDX_W-1:0] vic_frame
);

  logic [NUM_FRAMES-1:0] ref_q;
  age_t                  hist_q [NUM_FRAMES];
  logic                  scan_busy;
  logic                  age_pend_q;
  logic                  age_fire;

  // histories stay frozen while the scan walks them
  assign age_fire = (tick | age_pend_q) & ~scan_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      age_pend_q <= 1'b0;
    end else begin
      age_pend_q <= (tick & scan_busy) | (age_pend_q & ~age_fire);
    end
  end

  lru_ref_bits #(
    .NUM_FRAMES (NUM_FRAMES),
    .FRAME_IDX_W(FRAME_IDX_W)
  ) u_ref (
    .clk      (clk),
    .rst      (rst),
    .acc_valid(acc_valid),
    .acc_frame(acc_frame),
    .clr_valid(clr_valid),
    .clr_frame(clr_frame),
    .age_fire (age_fire),
    .ref_q    (ref_q)
  );

  lru_history #(
    .NUM_FRAMES(NUM_FRAMES)
  ) u_hist (
    .clk     (clk),
    .rst     (rst),
    .age_fire(age_fire),
    .ref_q   (ref_q),
    .hist_q  (hist_q)
  );

  lru_victim_scan #(
    .NUM_FRAMES (NUM_FRAMES),
    .FRAME_IDX_W(FRAME_IDX_W)
  ) u_scan (
    .clk   (clk),
    .rst   (rst),
    .start (vic_req),
    .hist  (hist_q),
    .busy  (scan_busy),
    .done  (vic_done),
    .victim(vic_frame)
  );

  assign vic_busy = scan_busy;

endmodule

// File: rtl/lru_checker.sv
module lru_checker
  import aging_lru_pkg::*;
#(
  parameter int unsigned NUM_FRAMES  = 16,
  parameter int unsigned FRAME_IDX_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   acc_valid,
  input logic [FRAME_IDX_W-1:0] acc_frame,
  input logic                   vic_req,
  input logic                   vic_busy,
  input logic                   vic_done,
  input logic [FRAME_IDX_W-1:0] vic_frame,
  input logic                   age_fire,
  input logic [NUM_FRAMES-1:0]  ref_q,
  input age_t                   hist_q [NUM_FRAMES]
);

  localparam int unsigned CNT_W = FRAME_IDX_W + 2;

  logic [CNT_W-1:0] busy_len_q;

  always_ff @(posedge clk) begin
    if (rst || !vic_busy) begin
      busy_len_q <= '0;
    end else begin
      busy_len_q <= busy_len_q + 1'b1;
    end
  end

  assert_flag_set_R2: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> ref_q[$past(acc_frame)]);

  assert_scan_starts_R8: assert property (@(posedge clk) disable iff (rst)
    vic_req && !vic_busy |=> vic_busy);

  assert_done_follows_busy_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(vic_busy) |-> vic_done);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    vic_done |=> !vic_done);

  assert_busy_length_R8: assert property (@(posedge clk) disable iff (rst)
    vic_done |-> busy_len_q == CNT_W'(NUM_FRAMES));

  assert_victim_in_range_R7: assert property (@(posedge clk) disable iff (rst)
    vic_done |-> int'(vic_frame) < NUM_FRAMES);

  for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_frame
    assert_top_bit_from_flag_R4: assert property (@(posedge clk) disable iff (rst)
      age_fire |=> hist_q[i][AGE_W-1] == $past(ref_q[i]));

    assert_flag_cleared_R5: assert property (@(posedge clk) disable iff (rst)
      age_fire && !(acc_valid && acc_frame == FRAME_IDX_W'(i)) |=> !ref_q[i]);

    assert_hist_frozen_R10: assert property (@(posedge clk) disable iff (rst)
      vic_busy |=> $stable(hist_q[i]));
  end

endmodule

bind aging_lru_unit lru_checker #(
  .NUM_FRAMES (NUM_FRAMES),
  .FRAME_IDX_W(FRAME_IDX_W)
) u_lru_checker (
  .clk      (clk),
  .rst      (rst),
  .acc_valid(acc_valid),
  .acc_frame(acc_frame),
  .vic_req  (vic_req),
  .vic_busy (vic_busy),
  .vic_done (vic_done),
  .vic_frame(vic_frame),
  .age_fire (age_fire),
  .ref_q    (ref_q),
  .hist_q   (hist_q)
);

// File: tb/aging_lru_unit_bench.sv
module aging_lru_unit_bench;

  localparam int N  = 16;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_valid = 1'b0;
  logic [IW-1:0] acc_frame = '0;
  logic          tick = 1'b0;
  logic          clr_valid = 1'b0;
  logic [IW-1:0] clr_frame = '0;
  logic          vic_req = 1'b0;
  logic          vic_busy;
  logic          vic_done;
  logic [IW-1:0] vic_frame;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  aging_lru_unit #(.NUM_FRAMES(N)) u_aging_lru_unit (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_frame(acc_frame),
    .tick(tick), .clr_valid(clr_valid), .clr_frame(clr_frame),
    .vic_req(vic_req), .vic_busy(vic_busy), .vic_done(vic_done),
    .vic_frame(vic_frame)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_flag [N];
  int m_age  [N];
  bit m_busy, m_done, m_pend;
  int m_left, m_vic, m_pick;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_flag[i]) begin m_flag[i] = 0; m_age[i] = 0; end
      m_busy = 0; m_done = 0; m_pend = 0; m_left = 0; m_vic = 0; m_pick = 0;
    end else begin
      bit do_age;
      do_age = (tick || m_pend) && !m_busy;
      m_pend = (tick && m_busy) || (m_pend && !do_age);
      if (do_age) begin
        foreach (m_age[i]) begin
          m_age[i] = (m_age[i] >> 1) + (m_flag[i] ? 128 : 0);
          m_flag[i] = 0;
        end
      end
      if (clr_valid) m_flag[clr_frame] = 0;
      if (acc_valid) m_flag[acc_frame] = 1;
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0;
          m_done = 1;
          m_vic  = m_pick;
        end
      end else if (vic_req) begin
        m_busy = 1;
        m_left = N;
        m_pick = 0;
        for (int i = 1; i < N; i++) if (m_age[i] < m_age[m_pick]) m_pick = i;
      end
    end
  end

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check(vic_busy == m_busy, "R8 busy vs model", vic_busy, m_busy);
      check(vic_done == m_done, "R8 done vs model", vic_done, m_done);
      check(int'(vic_frame) == m_vic, "R7 victim vs model", vic_frame, m_vic);
    end
  end

  task automatic drive(input bit av, input int af, input bit tk,
                       input bit cv, input int cf, input bit rq);
    acc_valid = av; acc_frame = IW'(af); tick = tk;
    clr_valid = cv; clr_frame = IW'(cf); vic_req = rq;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
  endtask

  task automatic touch_all_but(input int skip_a, input int skip_b);
    for (int f = 0; f < N; f++) if (f != skip_a && f != skip_b) drive(1, f, 0, 0, 0, 0);
  endtask

  task automatic ask(input int exp, input string tag);
    drive(0, 0, 0, 0, 0, 1);
    for (int k = 0; k < 40 && !vic_done; k++) idle(1);
    check(vic_done && int'(vic_frame) == exp, tag, vic_frame, exp);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check(vic_busy == 0, "R1 busy after reset", vic_busy, 0);
    check(vic_done == 0, "R1 done after reset", vic_done, 0);
    check(vic_frame == 0, "R1 victim after reset", vic_frame, 0);
    rst = 1'b0;
    cmp_on = 1;

    // R7: all histories equal -> lowest index
    ask(0, "R7 tie picks frame 0");

    // R2 R4: every frame but 5 touched, one aging step
    touch_all_but(5, 5);
    drive(0, 0, 1, 0, 0, 0);
    ask(5, "R2 R4 untouched frame is victim");

    // R5: flags cleared by aging, then only 5 touched
    drive(0, 0, 1, 0, 0, 0);
    drive(1, 5, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0);
    ask(0, "R5 flags cleared on aging");

    // R3: clear one flag
    do_reset();
    touch_all_but(N, N);
    drive(0, 0, 0, 1, 7, 0);
    drive(0, 0, 1, 0, 0, 0);
    ask(7, "R3 cleared frame becomes victim");

    // R3: access wins over clear in the same cycle
    do_reset();
    touch_all_but(2, 2);
    drive(1, 2, 0, 1, 2, 0);
    drive(0, 0, 1, 0, 0, 0);
    ask(0, "R3 access beats clear");

    // R6: access in the tick cycle lands in the next interval
    do_reset();
    touch_all_but(4, 4);
    drive(1, 4, 1, 0, 0, 0);
    ask(4, "R6 tick-cycle access not in this step");
    drive(0, 0, 1, 0, 0, 0);
    ask(0, "R6 tick-cycle access kept for next step");

    // R9: request held high during a scan
    begin
      int busy_n = 0, done_n = 0;
      drive(0, 0, 0, 0, 0, 1);
      for (int k = 0; k < N + 6; k++) begin
        busy_n += vic_busy;
        done_n += vic_done;
        drive(0, 0, 0, 0, 0, k < N - 2);
      end
      check(busy_n == N, "R9 scan length with held request", busy_n, N);
      check(done_n == 1, "R9 single done with held request", done_n, 1);
      idle(4);
    end

    // R10: tick during a scan is deferred
    do_reset();
    touch_all_but(11, 11);
    drive(0, 0, 1, 0, 0, 0);
    touch_all_but(0, 0);
    drive(0, 0, 0, 0, 0, 1);
    idle(3);
    drive(0, 0, 1, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0);
    for (int k = 0; k < 40 && !vic_done; k++) idle(1);
    check(vic_done && vic_frame == 11, "R10 scan sees frozen histories", vic_frame, 11);
    ask(0, "R10 merged deferred step applied after scan");

    // mixed traffic against the model, varied tick spacing
    do_reset();
    begin
      int period = 9, cnt = 0;
      for (int c = 0; c < 6000; c++) begin
        bit tk;
        tk = (cnt >= period);
        if (tk) begin cnt = 0; period = 3 + int'($urandom % 60); end
        else cnt++;
        drive($urandom % 3 != 0, int'($urandom % N), tk,
              $urandom % 9 == 0, int'($urandom % N), $urandom % 25 == 0);
      end
    end
    idle(N + 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    check(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule